// File: doc/BRIEF.md
# Transaction Order Tracking Checker

This block checks that write requests and doorbell messages keep their relative order across a serial link. On the sending side it sees an issue event for each transaction. On the receiving side it sees a completion event for each transaction that arrives. Each event carries its class as a single tag bit, and the block appends that bit to a record for its side. When the surrounding test raises a check strobe, the two records are compared. The block then reports either an exact match or a mismatch.

Some write transactions are cancelled after they are issued and never reach the far side. For these, a cancel input names a position in the send-side record, and that write tag is taken out before the comparison. Both records have a fixed capacity. Events beyond the capacity are dropped and raise a sticky overflow flag, and an overflowed run can never pass. A synchronous clear starts a new run.

Top module: `otc_order_checker`

## Requirements
- R1: Each record stores one tag per event, in arrival order: a write as 0 and a doorbell as 1. Events are accepted on every cycle, including back-to-back cycles.
- R2: When a write and a doorbell arrive on the same side in the same cycle, the write tag is stored ahead of the doorbell tag.
- R3: `result_vld_o` pulses high for exactly the one cycle that follows a cycle with `check_i` high. `pass_o` and `mismatch_o` keep their values until the next check or clear.
- R4: A check passes (`pass_o`=1, `mismatch_o`=0) only if both records hold the same number of tags and the tags are equal position by position. Any other check gives `pass_o`=0 and `mismatch_o`=1. Two empty records pass.
- R5: When `cancel_i` is high, `cancel_pos_i` is below the send-side count, and the tag at that position (0 = oldest) is a write, that tag is removed. The younger tags each move one position toward the oldest.
- R6: A cancel has no effect when its position is at or beyond the send-side count, or when it points at a doorbell tag.
- R7: A cancel and send-side events in the same cycle are applied in that order: the removal happens first, then the new tags are appended.
- R8: Each record holds DEPTH tags (default 40). An event that finds its record full is discarded and sets `overflow_o`. `overflow_o` stays set until clear, and while it is set every check reports a mismatch.
- R9: A cycle with `clr_i` high empties both records and drives `result_vld_o`, `pass_o`, `mismatch_o` and `overflow_o` low on the next cycle.
- R10: After reset, all four status outputs are low and both records are empty.
- R11: A check compares the records as they stood before any events or cancel that arrive in the same cycle as the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous clear of both records and all flags |
| snd_wr_i | input | 1 | Write request issued on the sending side |
| snd_db_i | input | 1 | Doorbell issued on the sending side |
| cancel_i | input | 1 | Remove a cancelled write from the send record |
| cancel_pos_i | input | $clog2(DEPTH) | Record position of the cancelled write, 0 = oldest |
| rcv_wr_i | input | 1 | Write request completed on the receiving side |
| rcv_db_i | input | 1 | Doorbell received on the receiving side |
| check_i | input | 1 | Compare the two records |
| result_vld_o | output | 1 | One-cycle pulse: a comparison result is available |
| pass_o | output | 1 | Last comparison was an exact match |
| mismatch_o | output | 1 | Last comparison failed |
| overflow_o | output | 1 | Sticky: an event found its record full |

## Verification
All internal state is hidden, so it shows up only through the next comparison. A tag stored at the wrong position, a lost shift after a cancel, or a miscounted record turns an expected pass into a mismatch, or the reverse, in the cycle right after the following check strobe. The sweep feeds every four-cycle send pattern in three ways: mirrored pairs, the same tags serialized one per cycle, and a copy with one tag corrupted. An error in same-cycle ordering or bit placement therefore shows up within about a dozen cycles. A wrong overflow counter is visible on `overflow_o` one cycle after the event that should have been dropped.

// File: rtl/otc_pkg.sv
`timescale 1ns/1ps
package otc_pkg;

  // Tag class carried by every issue or completion event
  typedef enum logic {
    TAG_WR = 1'b0,
    TAG_DB = 1'b1
  } otc_tag_e;

  // Default record capacity
  localparam int unsigned OTC_DEPTH = 40;

endpackage

// File: rtl/otc_tag_queue.sv
`timescale 1ns/1ps
// One-bit class record for one side of the link. The send side enables
// removal of a cancelled write; the receive side builds without it.
module otc_tag_queue
  import otc_pkg::*;
#(
  parameter int unsigned DEPTH   = OTC_DEPTH,
  parameter bit          DROP_EN = 1'b1,
  localparam int         CW      = $clog2(DEPTH + 1),
  localparam int         PW      = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push_wr,
  input  logic             push_db,
  input  logic             drop_vld,
  input  logic [PW-1:0]    drop_pos,
  output logic [DEPTH-1:0] tags,
  output logic [CW-1:0]    count,
  output logic             ovf
);

  logic [DEPTH-1:0] q_r;
  logic [DEPTH-1:0] q_shift;
  logic [DEPTH-1:0] q_nxt;
  logic [CW-1:0]    cnt_r;
  logic [CW-1:0]    cnt_nxt;
  logic             ovf_r;
  logic             ovf_set;
  logic             pick;
  logic             drop_ok;

  // A removal is legal only inside the filled part and only on a write tag
  always_comb begin
    pick = TAG_DB;
    for (int i = 0; i < DEPTH; i++) begin
      if (int'(drop_pos) == i) pick = q_r[i];
    end
    drop_ok = DROP_EN && drop_vld && (int'(drop_pos) < int'(cnt_r)) && (pick == TAG_WR);
  end

  // Close the gap left by a removed tag: every younger tag moves one slot down
  for (genvar g = 0; g < DEPTH; g++) begin : g_shift
    if (!DROP_EN) begin : g_keep
      assign q_shift[g] = q_r[g];
    end else if (g == DEPTH - 1) begin : g_top
      assign q_shift[g] = (drop_ok && (int'(drop_pos) <= g)) ? 1'b0 : q_r[g];
    end else begin : g_mid
      assign q_shift[g] = (drop_ok && (int'(drop_pos) <= g)) ? q_r[g+1] : q_r[g];
    end
  end

  // Append after the removal; the write goes ahead of the doorbell
  always_comb begin
    int slot;
    q_nxt   = q_shift;
    ovf_set = 1'b0;
    slot    = int'(cnt_r) - (drop_ok ? 1 : 0);
    if (push_wr) begin
      if (slot < DEPTH) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (i == slot) q_nxt[i] = TAG_WR;
        end
        slot++;
      end else begin
        ovf_set = 1'b1;
      end
    end
    if (push_db) begin
      if (slot < DEPTH) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (i == slot) q_nxt[i] = TAG_DB;
        end
        slot++;
      end else begin
        ovf_set = 1'b1;
      end
    end
    cnt_nxt = CW'(slot);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q_r   <= '0;
      cnt_r <= '0;
      ovf_r <= 1'b0;
    end else begin
      q_r   <= q_nxt;
      cnt_r <= cnt_nxt;
      ovf_r <= ovf_r | ovf_set;
    end
  end

  assign tags  = q_r;
  assign count = cnt_r;
  assign ovf   = ovf_r;

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_r <= CW'(DEPTH));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_r && !clr) |=> ovf_r);

  // R9
  clr_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_r == '0 && !ovf_r));

  // R1
  single_push_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && (push_wr ^ push_db) && !drop_vld && (cnt_r < CW'(DEPTH)))
      |=> (cnt_r == $past(cnt_r) + 1'b1));

endmodule

// File: rtl/otc_seq_compare.sv
`timescale 1ns/1ps
// Compares the two records on a strobe. The result is registered and held.
module otc_seq_compare
  import otc_pkg::*;
#(
  parameter int unsigned DEPTH = OTC_DEPTH,
  localparam int         CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             chk,
  input  logic [DEPTH-1:0] snd_tags,
  input  logic [DEPTH-1:0] rcv_tags,
  input  logic [CW-1:0]    snd_cnt,
  input  logic [CW-1:0]    rcv_cnt,
  input  logic             ovf,
  output logic             res_vld,
  output logic             pass,
  output logic             mism
);

  logic [DEPTH-1:0] live;
  logic             diff;
  logic             bad;

  // Only the filled positions take part in the comparison
  for (genvar g = 0; g < DEPTH; g++) begin : g_live
    assign live[g] = (int'(snd_cnt) > g);
  end

  always_comb begin
    diff = |((snd_tags ^ rcv_tags) & live);
    bad  = (snd_cnt != rcv_cnt) || ovf || diff;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      res_vld <= 1'b0;
      pass    <= 1'b0;
      mism    <= 1'b0;
    end else begin
      res_vld <= chk;
      if (chk) begin
        pass <= !bad;
        mism <= bad;
      end
    end
  end

  // R3
  res_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (chk && !clr) |=> res_vld);

  // R3
  res_only_after_chk: assert property (@(posedge clk) disable iff (rst)
    !chk |=> !res_vld);

  // R3
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!chk && !clr) |=> ($stable(pass) && $stable(mism)));

  // R4
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(pass && mism));

  // R8
  ovf_forces_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (chk && ovf && !clr) |=> mism);

endmodule

// File: rtl/otc_order_checker.sv
`timescale 1ns/1ps
// Top: send record with cancel support, receive record, and comparator.
module otc_order_checker
  import otc_pkg::*;
#(
  parameter int unsigned DEPTH = OTC_DEPTH,
  localparam int         CW    = $clog2(DEPTH + 1),
  localparam int         PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          snd_wr_i,
  input  logic          snd_db_i,
  input  logic          cancel_i,
  input  logic [PW-1:0] cancel_pos_i,
  input  logic          rcv_wr_i,
  input  logic          rcv_db_i,
  input  logic          check_i,
  output logic          result_vld_o,
  output logic          pass_o,
  output logic          mismatch_o,
  output logic          overflow_o
);

  logic [DEPTH-1:0] snd_tags;
  logic [DEPTH-1:0] rcv_tags;
  logic [CW-1:0]    snd_cnt;
  logic [CW-1:0]    rcv_cnt;
  logic             snd_ovf;
  logic             rcv_ovf;

  otc_tag_queue #(.DEPTH(DEPTH), .DROP_EN(1'b1)) u_snd_q (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr_i),
    .push_wr  (snd_wr_i),
    .push_db  (snd_db_i),
    .drop_vld (cancel_i),
    .drop_pos (cancel_pos_i),
    .tags     (snd_tags),
    .count    (snd_cnt),
    .ovf      (snd_ovf)
  );

  otc_tag_queue #(.DEPTH(DEPTH), .DROP_EN(1'b0)) u_rcv_q (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr_i),
    .push_wr  (rcv_wr_i),
    .push_db  (rcv_db_i),
    .drop_vld (1'b0),
    .drop_pos ('0),
    .tags     (rcv_tags),
    .count    (rcv_cnt),
    .ovf      (rcv_ovf)
  );

  otc_seq_compare #(.DEPTH(DEPTH)) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr_i),
    .chk      (check_i),
    .snd_tags (snd_tags),
    .rcv_tags (rcv_tags),
    .snd_cnt  (snd_cnt),
    .rcv_cnt  (rcv_cnt),
    .ovf      (snd_ovf | rcv_ovf),
    .res_vld  (result_vld_o),
    .pass     (pass_o),
    .mism     (mismatch_o)
  );

  assign overflow_o = snd_ovf | rcv_ovf;

  // R9
  clear_quiets_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (!result_vld_o && !pass_o && !mismatch_o && !overflow_o));

endmodule

// File: tb/otc_order_checker_tb.sv
`timescale 1ns/1ps
module otc_order_checker_tb;

  localparam int DEPTH = 40;
  localparam int PW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst;
  logic          clr_i;
  logic          snd_wr_i, snd_db_i, cancel_i;
  logic [PW-1:0] cancel_pos_i;
  logic          rcv_wr_i, rcv_db_i, check_i;
  logic          result_vld_o, pass_o, mismatch_o, overflow_o;

  always #2.5 clk = ~clk;

  otc_order_checker #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .clr_i(clr_i),
    .snd_wr_i(snd_wr_i), .snd_db_i(snd_db_i),
    .cancel_i(cancel_i), .cancel_pos_i(cancel_pos_i),
    .rcv_wr_i(rcv_wr_i), .rcv_db_i(rcv_db_i), .check_i(check_i),
    .result_vld_o(result_vld_o), .pass_o(pass_o),
    .mismatch_o(mismatch_o), .overflow_o(overflow_o)
  );

  int checks = 0;
  int errors = 0;

  // Requirement-level model of the two records
  bit sm[64];
  bit rm[64];
  int sc, rc;
  bit movf;
  bit snap[64];
  int sn;

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit model_pass();
    if (movf || sc != rc) return 1'b0;
    for (int i = 0; i < sc; i++) if (sm[i] != rm[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic m_spush(bit v);
    if (sc < DEPTH) begin sm[sc] = v; sc++; end else movf = 1'b1;
  endtask

  task automatic m_rpush(bit v);
    if (rc < DEPTH) begin rm[rc] = v; rc++; end else movf = 1'b1;
  endtask

  task automatic m_cancel(int pos);
    if (pos < sc && sm[pos] == 1'b0) begin
      for (int i = pos; i < sc - 1; i++) sm[i] = sm[i+1];
      sc--;
    end
  endtask

  task automatic step(bit sw, bit sd, bit cv, int cp, bit rw, bit rd, bit ck, string req);
    bit ep;
    ep = model_pass();
    snd_wr_i = sw; snd_db_i = sd; cancel_i = cv; cancel_pos_i = cp[PW-1:0];
    rcv_wr_i = rw; rcv_db_i = rd; check_i = ck;
    if (cv) m_cancel(cp);
    if (sw) m_spush(1'b0);
    if (sd) m_spush(1'b1);
    if (rw) m_rpush(1'b0);
    if (rd) m_rpush(1'b1);
    @(posedge clk); #1;
    snd_wr_i = 0; snd_db_i = 0; cancel_i = 0; rcv_wr_i = 0; rcv_db_i = 0; check_i = 0;
    check_eq(req, "result_vld", int'(result_vld_o), int'(ck));
    if (ck) begin
      check_eq(req, "pass", int'(pass_o), int'(ep));
      check_eq(req, "mismatch", int'(mismatch_o), int'(!ep));
    end
    check_eq("R8", "overflow", int'(overflow_o), int'(movf));
  endtask

  task automatic do_clear();
    clr_i = 1'b1;
    @(posedge clk); #1;
    clr_i = 1'b0;
    sc = 0; rc = 0; movf = 1'b0;
    check_eq("R9", "clear vld", int'(result_vld_o), 0);
    check_eq("R9", "clear pass", int'(pass_o), 0);
    check_eq("R9", "clear mismatch", int'(mismatch_o), 0);
    check_eq("R9", "clear overflow", int'(overflow_o), 0);
  endtask

  // Feed the snapshot to the receive side one tag per cycle
  task automatic replay_snap();
    for (int i = 0; i < sn; i++) step(0, 0, 0, 0, !snap[i], snap[i], 0, "R1");
  endtask

  task automatic take_snap();
    sn = sc;
    for (int i = 0; i < sc; i++) snap[i] = sm[i];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; clr_i = 0;
    snd_wr_i = 0; snd_db_i = 0; cancel_i = 0; cancel_pos_i = '0;
    rcv_wr_i = 0; rcv_db_i = 0; check_i = 0;
    sc = 0; rc = 0; movf = 0;
    repeat (3) @(posedge clk);
    #1;
    check_eq("R10", "reset vld", int'(result_vld_o), 0);
    check_eq("R10", "reset pass", int'(pass_o), 0);
    check_eq("R10", "reset mismatch", int'(mismatch_o), 0);
    check_eq("R10", "reset overflow", int'(overflow_o), 0);
    rst = 1'b0;

    // R4: two empty records match
    step(0, 0, 0, 0, 0, 0, 1, "R4");

    // Sweep every four-cycle send pattern: mirrored pairs (R2),
    // serialized replay (R1) and a corrupted replay (R4)
    for (int p = 0; p < 256; p++) begin
      for (int v = 0; v < 3; v++) begin
        do_clear();
        for (int k = 0; k < 4; k++) begin
          if (v == 0) step(p[2*k], p[2*k+1], 0, 0, p[2*k], p[2*k+1], 0, "R2");
          else        step(p[2*k], p[2*k+1], 0, 0, 0, 0, 0, "R1");
        end
        if (v >= 1) begin
          take_snap();
          if (v == 2) begin
            if (sn > 0) snap[sn-1] = !snap[sn-1];
            else begin snap[0] = 1'b1; sn = 1; end
          end
          replay_snap();
        end
        step(0, 0, 0, 0, 0, 0, 1, (v == 0) ? "R2" : ((v == 1) ? "R1" : "R4"));
      end
    end

    // R5 / R6: cancel at every position of W D W W D W and beyond the count
    for (int cp = 0; cp < 8; cp++) begin
      bit seq[6];
      seq = '{0, 1, 0, 0, 1, 0};
      do_clear();
      for (int i = 0; i < 6; i++) step(!seq[i], seq[i], 0, 0, 0, 0, 0, "R1");
      step(0, 0, 1, cp, 0, 0, 0, (cp < 6 && seq[cp] == 0) ? "R5" : "R6");
      take_snap();
      replay_snap();
      step(0, 0, 0, 0, 0, 0, 1, (cp < 6 && seq[cp] == 0) ? "R5" : "R6");
    end

    // R7: cancel of the oldest write in the same cycle as a new W and D
    do_clear();
    step(1, 0, 0, 0, 0, 0, 0, "R7");
    step(0, 1, 0, 0, 0, 0, 0, "R7");
    step(1, 1, 1, 0, 0, 0, 0, "R7");
    take_snap();
    check_eq("R7", "model length", sn, 3);
    replay_snap();
    step(0, 0, 0, 0, 0, 0, 1, "R7");

    // R11: the strobe sees the records before same-cycle events
    do_clear();
    step(1, 0, 0, 0, 1, 0, 0, "R11");
    step(0, 1, 0, 0, 0, 0, 1, "R11");
    step(0, 0, 0, 0, 0, 0, 1, "R11");

    // R3: flags held with no strobe
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 0, 0, 1, 1, 0, "R3");
      check_eq("R3", "held mismatch", int'(mismatch_o), 1);
      check_eq("R3", "held pass", int'(pass_o), 0);
    end

    // R8: one write too many on the send side
    do_clear();
    for (int i = 0; i < DEPTH + 1; i++) step(1, 0, 0, 0, 0, 0, 0, "R8");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 1, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 1, "R8");

    // R8: W and D in the last free slot, the doorbell is dropped
    do_clear();
    for (int i = 0; i < DEPTH - 1; i++) step(1, 0, 0, 0, 1, 0, 0, "R8");
    step(1, 1, 0, 0, 1, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 1, "R8");

    // R9: clearing restores a passing empty state
    do_clear();
    step(0, 0, 0, 0, 0, 0, 1, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule